// File: doc/BRIEF.md
# Register Renaming Stage

This block sits between instruction decode and a dependency-level scheduler. Each instruction arrives in program order and carries up to one destination and two source register numbers, each with a presence flag. The block rewrites these fields into physical tags. Every destination gets a tag that no earlier instruction has used. Each source is redirected to the tag most recently given to its architected register. Anti dependencies (write after read) and output dependencies (write after write) therefore vanish, and only true read-after-write links remain for the scheduler.

Tags come from an allocation counter that starts at a fixed base (10 by default) and only counts upward. Tags are never reclaimed. An architected register that has not been written since reset keeps its own number as its tag.

A mode input selects renaming or bypass. In bypass, tags equal the architected numbers and no state changes. Instructions enter and leave on valid/ready streams with one registered output stage:
- An input item is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output field holds steady.

Top module: `rename_stage`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low and `in_ready` is high.
- R2: With `rename_en` high, each accepted instruction whose destination flag is set receives a new tag. The first tag after reset is 10, and each later one is one greater, in acceptance order. This holds even when the same architected register is written again.
- R3: With renaming on, a present source whose architected register has not been renamed since reset gets its architected number, zero-extended, as its tag.
- R4: With renaming on, a present source whose architected register has been renamed gets the tag most recently allocated to that register.
- R5: When an instruction reads and writes the same architected register, its source sees the mapping in force before that instruction's own allocation.
- R6: An instruction with the destination flag clear (such as a store) allocates nothing. Each presence flag is passed through unchanged, and a field whose flag is clear outputs tag 0.
- R7: With `rename_en` low, every present field's tag equals its architected number. Neither the map nor the counter changes, which later renamed instructions make visible.
- R8: An item moves when valid and ready are both high. Outputs leave in the order they were accepted, one per accepted input. While `out_valid` is high and `out_ready` is low, all output fields stay stable.
- R9: The all-ones tag (255) is the last fresh tag. A later allocating instruction gets 255 again and sets `overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rename_en | input | 1 | 1 = rename, 0 = bypass |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can take an item |
| in_dst_vld | input | 1 | Destination present |
| in_dst_arch | input | 3 | Destination architected register |
| in_src1_vld | input | 1 | First source present |
| in_src1_arch | input | 3 | First source architected register |
| in_src2_vld | input | 1 | Second source present |
| in_src2_arch | input | 3 | Second source architected register |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Consumer takes the item |
| out_dst_vld | output | 1 | Destination present |
| out_dst_tag | output | 8 | Destination tag |
| out_src1_vld | output | 1 | First source present |
| out_src1_tag | output | 8 | First source tag |
| out_src2_vld | output | 1 | Second source present |
| out_src2_tag | output | 8 | Second source tag |
| overflow | output | 1 | Sticky: allocation past the last tag |

## Verification
The bench first repeats a register: it writes one register twice and reads it in the same instruction. A design that updates the map before lookup would hand the source its own new tag. A design that reuses tags would break the consecutive numbering.

It then runs bypass instructions between renamed ones. A block that lets bypass touch the map or counter shows shifted tags afterwards.

Random back-pressure checks that stalled outputs hold still and stay in order.

Finally, the counter is driven to its end. A design that wraps would give a small tag instead of 255, or raise `overflow` one allocation early or late.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned ARCH_N_DEF   = 8;
  localparam int unsigned TAG_W_DEF    = 8;
  localparam int unsigned TAG_BASE_DEF = 10;
  localparam int unsigned N_SRC        = 2;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned ARCH_N = 8,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned N_RD   = 2,
  localparam int unsigned AW    = $clog2(ARCH_N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_RD-1:0][AW-1:0]    rd_idx,
  output logic [N_RD-1:0][TAG_W-1:0] rd_tag,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_idx,
  input  logic [TAG_W-1:0]           wr_tag
);
  logic [TAG_W-1:0] map_q [ARCH_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= TAG_W'(i);
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  // lookups read the state before this cycle's write
  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_tag[g] = map_q[rd_idx[g]];
  end
endmodule

// File: rtl/rename_tag_alloc.sv
module rename_tag_alloc #(
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned TAG_BASE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  output logic [TAG_W-1:0] tag,
  output logic             ovf
);
  // one extra bit marks that the last tag has been handed out
  logic [TAG_W:0] cnt_q;
  logic           ovf_q;
  logic           spent;

  assign spent = cnt_q[TAG_W];
  assign tag   = spent ? {TAG_W{1'b1}} : cnt_q[TAG_W-1:0];
  assign ovf   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= (TAG_W+1)'(TAG_BASE);
      ovf_q <= 1'b0;
    end else if (alloc) begin
      if (spent) ovf_q <= 1'b1;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rename_out_reg.sv
module rename_out_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/rename_stage.sv
module rename_stage #(
  parameter int unsigned ARCH_N   = rename_pkg::ARCH_N_DEF,
  parameter int unsigned TAG_W    = rename_pkg::TAG_W_DEF,
  parameter int unsigned TAG_BASE = rename_pkg::TAG_BASE_DEF,
  localparam int unsigned ARCH_W  = $clog2(ARCH_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rename_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dst_vld,
  input  logic [ARCH_W-1:0] in_dst_arch,
  input  logic              in_src1_vld,
  input  logic [ARCH_W-1:0] in_src1_arch,
  input  logic              in_src2_vld,
  input  logic [ARCH_W-1:0] in_src2_arch,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_dst_vld,
  output logic [TAG_W-1:0]  out_dst_tag,
  output logic              out_src1_vld,
  output logic [TAG_W-1:0]  out_src1_tag,
  output logic              out_src2_vld,
  output logic [TAG_W-1:0]  out_src2_tag,
  output logic              overflow
);
  localparam int unsigned NS   = rename_pkg::N_SRC;
  localparam int unsigned LW   = TAG_W + 1;
  localparam int unsigned DW   = LW * (NS + 1);

  logic                       fire, alloc;
  logic [TAG_W-1:0]           new_tag;
  logic [NS-1:0][ARCH_W-1:0]  src_arch;
  logic [NS-1:0]              src_vld;
  logic [NS-1:0][TAG_W-1:0]   map_tag;
  logic [NS:0][LW-1:0]        lane;
  logic [NS:0][LW-1:0]        lane_q;
  logic                       st_ready;

  assign src_arch = {in_src2_arch, in_src1_arch};
  assign src_vld  = {in_src2_vld, in_src1_vld};
  assign in_ready = st_ready;
  assign fire     = in_valid && st_ready;
  assign alloc    = fire && rename_en && in_dst_vld;

  rename_map_table #(.ARCH_N(ARCH_N), .TAG_W(TAG_W), .N_RD(NS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_arch), .rd_tag(map_tag),
    .wr_en(alloc), .wr_idx(in_dst_arch), .wr_tag(new_tag)
  );

  rename_tag_alloc #(.TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_alloc (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .tag(new_tag), .ovf(overflow)
  );

  // lane 0 = destination, lanes 1..NS = sources; each lane = {present, tag}
  always_comb begin
    lane[0] = {in_dst_vld, in_dst_vld ? (rename_en ? new_tag : TAG_W'(in_dst_arch))
                                      : {TAG_W{1'b0}}};
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    always_comb begin
      lane[s+1] = {src_vld[s], src_vld[s] ? (rename_en ? map_tag[s] : TAG_W'(src_arch[s]))
                                          : {TAG_W{1'b0}}};
    end
  end

  rename_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(st_ready), .in_data(lane),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(lane_q)
  );

  assign {out_dst_vld,  out_dst_tag}  = lane_q[0];
  assign {out_src1_vld, out_src1_tag} = lane_q[1];
  assign {out_src2_vld, out_src2_tag} = lane_q[2];
endmodule

// File: rtl/rename_stage_chk.sv
module rename_stage_chk #(
  parameter int unsigned ARCH_N   = 8,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned TAG_BASE = 10,
  localparam int unsigned ARCH_W  = $clog2(ARCH_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rename_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_dst_vld,
  input logic [ARCH_W-1:0] in_dst_arch,
  input logic              in_src1_vld,
  input logic [ARCH_W-1:0] in_src1_arch,
  input logic              in_src2_vld,
  input logic [ARCH_W-1:0] in_src2_arch,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_dst_vld,
  input logic [TAG_W-1:0]  out_dst_tag,
  input logic              out_src1_vld,
  input logic [TAG_W-1:0]  out_src1_tag,
  input logic              out_src2_vld,
  input logic [TAG_W-1:0]  out_src2_tag,
  input logic              overflow
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dst_tag) &&
      $stable(out_src1_tag) && $stable(out_src2_tag) && $stable(out_dst_vld)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !rename_en && in_dst_vld && in_src1_vld) |=>
      (out_dst_tag == TAG_W'($past(in_dst_arch)) &&
       out_src1_tag == TAG_W'($past(in_src1_arch))));

  p_dst_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rename_en && in_dst_vld) |=>
      (out_dst_vld && out_dst_tag >= TAG_BASE));

  p_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_src2_vld) |-> (out_src2_tag == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(in_valid && in_ready && rename_en && in_dst_vld));
endmodule

bind rename_stage rename_stage_chk #(.ARCH_N(ARCH_N), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE))
  u_chk (.*);

// File: tb/test_rename_stage.sv
`timescale 1ns/1ps
module test_rename_stage;
  localparam time TCLK = 20ns;

  logic       clk = 1'b0, rst_n = 1'b0, rename_en = 1'b1;
  logic       in_valid = 1'b0, in_ready;
  logic       in_dst_vld = 1'b0, in_src1_vld = 1'b0, in_src2_vld = 1'b0;
  logic [2:0] in_dst_arch = '0, in_src1_arch = '0, in_src2_arch = '0;
  logic       out_valid, out_ready = 1'b1;
  logic       out_dst_vld, out_src1_vld, out_src2_vld, overflow;
  logic [7:0] out_dst_tag, out_src1_tag, out_src2_tag;

  rename_stage i_rename_stage (.*);

  always #(TCLK/2) clk = ~clk;

  typedef struct {
    bit dv; int dt; bit s1v; int s1t; bit s2v; int s2t; string req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  int map_m[8];
  int nxt = 10;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // consumer back-pressure, changed away from the sampling edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  // driver: computes expected tags from the requirements, then offers the item
  task automatic send(input bit ren, input bit dv, input int d, input bit s1v,
                      input int s1, input bit s2v, input int s2, input string req);
    exp_t e;
    e.req = req;
    e.dv  = dv;  e.s1v = s1v;  e.s2v = s2v;
    e.s1t = s1v ? (ren ? map_m[s1] : s1) : 0;
    e.s2t = s2v ? (ren ? map_m[s2] : s2) : 0;
    e.dt  = dv ? (ren ? (nxt > 255 ? 255 : nxt) : d) : 0;
    if (ren && dv) begin
      map_m[d] = e.dt;
      if (nxt <= 255) nxt++;
    end
    rename_en    = ren;
    in_dst_vld   = dv;  in_dst_arch  = 3'(d);
    in_src1_vld  = s1v; in_src1_arch = 3'(s1);
    in_src2_vld  = s2v; in_src2_arch = 3'(s2);
    in_valid     = 1'b1;
    while (!in_ready) @(negedge clk);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (q.size() != 0 || out_valid) @(negedge clk);
  endtask

  // monitor: pops and compares as results leave; also checks stall holding
  bit         was_stall = 1'b0;
  logic [7:0] held_d, held_1, held_2;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (was_stall) begin
        check(out_valid && out_dst_tag == held_d && out_src1_tag == held_1 &&
              out_src2_tag == held_2, "R8", "stalled output held", int'(out_dst_tag),
              int'(held_d));
      end
      was_stall = out_valid && !out_ready;
      held_d = out_dst_tag; held_1 = out_src1_tag; held_2 = out_src2_tag;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected output item", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_dst_vld == e.dv && int'(out_dst_tag) == e.dt, e.req, "dst tag",
                int'(out_dst_tag), e.dt);
          check(out_src1_vld == e.s1v && int'(out_src1_tag) == e.s1t, e.req, "src1 tag",
                int'(out_src1_tag), e.s1t);
          check(out_src2_vld == e.s2v && int'(out_src2_tag) == e.s2t, e.req, "src2 tag",
                int'(out_src2_tag), e.s2t);
        end
      end
    end
  end

  initial begin
    #(TCLK * 200000);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) map_m[i] = i;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready,   "R1", "in_ready after reset",  int'(in_ready), 1);
    check(!overflow,  "R1", "overflow after reset",  int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: repeated writes to one register, same-instruction read/write
    send(1, 1, 3, 1, 1, 1, 2, "R3");   // -> 10 / 1 / 2
    send(1, 1, 4, 1, 3, 0, 0, "R4");   // -> 11 / 10 / -
    send(1, 1, 3, 1, 5, 1, 6, "R2");   // -> 12 / 5 / 6
    send(1, 1, 3, 1, 3, 0, 0, "R5");   // -> 13 / 12 / -
    // R6: store has no destination; allocates nothing
    send(1, 0, 0, 1, 3, 1, 4, "R6");   // -/13/11
    send(1, 1, 7, 1, 7, 1, 3, "R6");   // -> 14 proves no allocation
    drain();

    // R7: bypass leaves map and counter untouched
    send(0, 1, 3, 1, 3, 1, 4, "R7");
    send(0, 1, 7, 1, 0, 0, 0, "R7");
    send(1, 1, 5, 1, 3, 1, 7, "R7");   // -> 15 / 13 / 14
    drain();

    // R8: random back-pressure with back-to-back traffic
    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++)
      send(i % 5 != 0, i % 3 != 0, i % 8, 1, (i * 3) % 8, i % 2 == 0, (i + 5) % 8, "R8");
    drain();
    stall_mode = 1'b0;

    // R9: walk the counter to its last tag
    while (nxt <= 255) send(1, 1, nxt % 8, 1, (nxt + 1) % 8, 0, 0, "R2");
    drain();
    check(!overflow, "R9", "overflow before exhaustion", int'(overflow), 0);
    send(1, 1, 2, 1, 2, 0, 0, "R9");  // gets 255 again
    drain();
    check(overflow, "R9", "overflow after exhaustion", int'(overflow), 1);
    send(0, 1, 1, 1, 2, 0, 0, "R9");
    send(1, 0, 0, 1, 2, 1, 6, "R4");  // src 2 -> 255
    drain();
    check(overflow, "R9", "overflow stays set", int'(overflow), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule